// File: doc/BRIEF.md
# External Bus Dynamic Sizing Unit

This block connects an internal bus master to a 16-bit external memory bus whose address areas may each be wired 8 bits or 16 bits wide. The master hands over one byte, word or longword request at a time. The block breaks the request into as many external cycles as the width of the target area requires. For every cycle it puts the right bytes on the correct byte lane, drives a strobe for each lane that carries data, and presents the cycle address. For reads it collects the returned bytes into one right-justified result.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The master must hold its request fields stable until that edge. While a request is in progress, `req_ready` stays low and the master is held off. The response side is a one-clock `rsp_valid` pulse that carries no back-pressure, so the master must take it in the clock where it appears. The area width bits are plain configuration inputs. The width of the target area is sampled when the request is accepted and is held for that whole request.

Top module: `ext_bus_sizer`

## Requirements
- R1: After reset `req_ready` is 1, and `ext_cyc`, `rsp_valid` and both lane strobes are 0. `req_ready` is 1 only while no request is in progress, and a request is accepted on the clock edge where `req_valid` and `req_ready` are both 1.
- R2: `req_size` is encoded as 0 byte, 1 word, 2 longword, and 3 is invalid. A request with an invalid size, or a word or longword request with `req_addr[0]`=1, causes no external cycle. The clock after acceptance it gives a `rsp_valid` pulse with `rsp_err`=1.
- R3: When the target area's bit in `area_wide` is 0 (a narrow area), a request takes one external cycle per byte: 1, 2 or 4 cycles. Every cycle uses only the upper lane (`ext_dout[15:8]` / `ext_din[15:8]`): `ext_hi_en` is 1 and `ext_lo_en` is 0.
- R4: When the target area's bit is 1 (a wide area), a byte or word request takes one external cycle and a longword takes two word cycles.
- R5: The first cycle uses the request address. Each later cycle adds 1 (narrow area) or 2 (wide area) to the previous cycle address. The most significant data is transferred first.
- R6: In a wide area, a byte at an even address uses the upper lane and a byte at an odd address uses the lower lane. A word cycle uses both lanes, with the lower-addressed (more significant) byte on the upper lane.
- R7: Each external cycle lasts exactly two clocks with `ext_cyc`=1. In the first (setup) clock both strobes are 0. In the second (strobe) clock a strobe is 1 only on the lanes carrying valid data. `ext_addr` holds the same value across both clocks.
- R8: For writes, `ext_we` is 1 during every clock of every external cycle of the request. The data bytes appear on the strobed lanes in the order given by R3 to R6.
- R9: Read bytes are sampled at the end of the strobe clock. They are returned on `rsp_rdata` in big-endian order and right-justified: a byte in bits 7:0, a word in bits 15:0, with the unused upper bits 0.
- R10: The clock after the strobe clock of the last external cycle, `rsp_valid` is 1 for exactly one clock with `rsp_err`=0. `req_ready` returns to 1 the clock after that.
- R11: Changing `area_wide` while a request is in progress has no effect on that request's cycle count, lanes or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| area_wide | input | 2**AREA_W | Per-area width bit, 1 = 16-bit area; the area is given by the top AREA_W address bits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 invalid |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 4*LANE_W | Write data, right-justified |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Request was rejected (valid with rsp_valid) |
| rsp_rdata | output | 4*LANE_W | Assembled read data (valid with rsp_valid) |
| ext_addr | output | ADDR_W | Address of the current external cycle |
| ext_cyc | output | 1 | External cycle in progress (setup and strobe clocks) |
| ext_we | output | 1 | Current external cycle is a write |
| ext_hi_en | output | 1 | Upper-lane strobe |
| ext_lo_en | output | 1 | Lower-lane strobe |
| ext_dout | output | 2*LANE_W | Write data on the two lanes |
| ext_din | input | 2*LANE_W | Read data from the two lanes |

## Verification
Several assertions hold on every clock:
- strobes appear only in the second clock of a cycle, and the address does not change across it;
- a narrow area never strobes the lower lane;
- a wide byte strobes exactly one lane;
- the completion pulse lasts one clock;
- a rejected request shows no bus activity;
- `req_ready` stays low during external cycles;
- a byte read comes back zero-extended.

Other behaviours can only be shown by the bench's scenarios run against its reference model:
- the order of bytes and address steps in multi-cycle transfers;
- the exact bytes that are assembled;
- the number of cycles for each size and width;
- the width sampled at acceptance while the configuration changes mid-request.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_RESP   = 2'd3
  } seq_state_t;

  // number of bytes moved by a request of the given size
  function automatic logic [2:0] size_bytes(input xfer_size_t sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bsz_req_check.sv
module bsz_req_check
  import bsz_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  xfer_size_t        size,
  input  logic              addr_odd,
  input  logic              wide,
  output logic              legal,
  output logic [BEAT_W-1:0] last_beat
);

  logic [2:0] nbytes;

  always_comb begin
    nbytes = size_bytes(size);
    legal  = 1'b1;
    if (size == SZ_RSVD) legal = 1'b0;
    if ((size == SZ_WORD || size == SZ_LONG) && addr_odd) legal = 1'b0;
    if (!wide) begin
      last_beat = BEAT_W'(nbytes - 3'd1);
    end else if (size == SZ_LONG) begin
      last_beat = BEAT_W'(1);
    end else begin
      last_beat = '0;
    end
  end

endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer
  import bsz_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide,
  input  xfer_size_t          size,
  input  logic                base_odd,
  input  logic [BEAT_W-1:0]   beat,
  input  logic [4*LANE_W-1:0] wdata,
  output logic                hi_en,
  output logic                lo_en,
  output logic [2*LANE_W-1:0] dout
);

  localparam int BUS_W = 2 * LANE_W;

  logic [2:0]        nbytes;
  logic [1:0]        byte_idx;
  logic [LANE_W-1:0] narrow_byte;

  always_comb begin
    nbytes      = size_bytes(size);
    // most significant byte leaves first
    byte_idx    = 2'(nbytes - 3'd1 - 3'(beat));
    narrow_byte = wdata[byte_idx*LANE_W +: LANE_W];
    if (!wide) begin
      hi_en = 1'b1;
      lo_en = 1'b0;
      dout  = {narrow_byte, {LANE_W{1'b0}}};
    end else if (size == SZ_BYTE) begin
      hi_en = !base_odd;
      lo_en = base_odd;
      dout  = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
    end else begin
      hi_en = 1'b1;
      lo_en = 1'b1;
      if (size == SZ_LONG && beat == '0) dout = wdata[4*LANE_W-1 -: BUS_W];
      else                               dout = wdata[BUS_W-1:0];
    end
  end

  // R3
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (hi_en && !lo_en));

  // R6
  wide_byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && size == SZ_BYTE) |-> ($countones({hi_en, lo_en}) == 1));

endmodule

// File: rtl/bsz_read_gather.sv
module bsz_read_gather
  import bsz_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                capture,
  input  logic                wide,
  input  xfer_size_t          size,
  input  logic                base_odd,
  input  logic [2*LANE_W-1:0] din,
  output logic [4*LANE_W-1:0] acc
);

  localparam int BUS_W  = 2 * LANE_W;
  localparam int DATA_W = 4 * LANE_W;

  logic [LANE_W-1:0] upper_lane;
  logic [LANE_W-1:0] lower_lane;

  assign upper_lane = din[BUS_W-1 -: LANE_W];
  assign lower_lane = din[LANE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (capture) begin
      if (!wide)
        acc <= {acc[DATA_W-LANE_W-1:0], upper_lane};
      else if (size == SZ_BYTE)
        acc <= {acc[DATA_W-LANE_W-1:0], (base_odd ? lower_lane : upper_lane)};
      else
        acc <= {acc[DATA_W-BUS_W-1:0], din};
    end
  end

endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AREA_W = 3,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<AREA_W)-1:0]  area_wide,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [1:0]              req_size,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [4*LANE_W-1:0]     req_wdata,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [4*LANE_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]       ext_addr,
  output logic                    ext_cyc,
  output logic                    ext_we,
  output logic                    ext_hi_en,
  output logic                    ext_lo_en,
  output logic [2*LANE_W-1:0]     ext_dout,
  input  logic [2*LANE_W-1:0]     ext_din
);

  localparam int DATA_W = 4 * LANE_W;
  localparam int BEAT_W = 2;

  seq_state_t        state_q;
  xfer_size_t        size_q;
  logic              wide_q, we_q, err_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BEAT_W-1:0] beat_q, last_q;

  logic              accept, area_sel_wide, legal_d, strobe_ph;
  logic              lane_hi, lane_lo;
  logic [BEAT_W-1:0] last_d;
  logic [ADDR_W-1:0] step_off;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign area_sel_wide = area_wide[req_addr[ADDR_W-1 -: AREA_W]];
  assign strobe_ph     = (state_q == ST_STROBE);

  bsz_req_check #(.BEAT_W(BEAT_W)) u_chk (
    .size      (xfer_size_t'(req_size)),
    .addr_odd  (req_addr[0]),
    .wide      (area_sel_wide),
    .legal     (legal_d),
    .last_beat (last_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      size_q  <= SZ_BYTE;
      wide_q  <= 1'b0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      base_q  <= '0;
      wdata_q <= '0;
      beat_q  <= '0;
      last_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          size_q  <= xfer_size_t'(req_size);
          wide_q  <= area_sel_wide;
          we_q    <= req_write;
          base_q  <= req_addr;
          wdata_q <= req_wdata;
          beat_q  <= '0;
          last_q  <= last_d;
          err_q   <= !legal_d;
          state_q <= legal_d ? ST_SETUP : ST_RESP;
        end
        ST_SETUP: state_q <= ST_STROBE;
        ST_STROBE: begin
          if (beat_q == last_q) begin
            state_q <= ST_RESP;
          end else begin
            beat_q  <= beat_q + BEAT_W'(1);
            state_q <= ST_SETUP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // address step per cycle: bytes in a narrow area, words in a wide one
  assign step_off = wide_q ? ADDR_W'({beat_q, 1'b0}) : ADDR_W'(beat_q);
  assign ext_addr = base_q + step_off;
  assign ext_cyc  = (state_q == ST_SETUP) || strobe_ph;
  assign ext_we   = ext_cyc && we_q;

  bsz_lane_steer #(.LANE_W(LANE_W), .BEAT_W(BEAT_W)) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (wide_q),
    .size     (size_q),
    .base_odd (base_q[0]),
    .beat     (beat_q),
    .wdata    (wdata_q),
    .hi_en    (lane_hi),
    .lo_en    (lane_lo),
    .dout     (ext_dout)
  );

  assign ext_hi_en = strobe_ph && lane_hi;
  assign ext_lo_en = strobe_ph && lane_lo;

  bsz_read_gather #(.LANE_W(LANE_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .capture  (strobe_ph && !we_q),
    .wide     (wide_q),
    .size     (size_q),
    .base_odd (base_q[0]),
    .din      (ext_din),
    .acc      (rsp_rdata)
  );

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc |-> !req_ready);

  // R10
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!ext_cyc && $past(!ext_cyc)));

  // R7
  strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hi_en || ext_lo_en) |-> (ext_cyc && $past(ext_cyc) && $stable(ext_addr)
                                  && !$past(ext_hi_en || ext_lo_en)));

  // R9
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && !we_q && size_q == SZ_BYTE)
      |-> (rsp_rdata[DATA_W-1:LANE_W] == '0));

endmodule

// File: tb/ext_bus_sizer_tb.sv
module ext_bus_sizer_tb;

  localparam int ADDR_W = 24;
  localparam int AREA_W = 3;
  localparam int LANE_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  area_wide = 8'b1010_1010;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [23:0] ext_addr;
  logic        ext_cyc, ext_we, ext_hi_en, ext_lo_en;
  logic [15:0] ext_dout, ext_din;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string scen = "reset";

  always #10 clk = ~clk;  // 50 MHz

  ext_bus_sizer #(.ADDR_W(ADDR_W), .AREA_W(AREA_W), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .area_wide(area_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ext_addr(ext_addr), .ext_cyc(ext_cyc), .ext_we(ext_we),
    .ext_hi_en(ext_hi_en), .ext_lo_en(ext_lo_en),
    .ext_dout(ext_dout), .ext_din(ext_din)
  );

  // ---------------- reference model ----------------
  int          m_st = 0;      // 0 idle, 1 setup, 2 strobe, 3 response
  int          m_beat, m_last, m_n, m_size;
  int          m_base;
  longint      m_wdata, m_exp_rd;
  bit          m_wide, m_we, m_err, m_acc;

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 29 + 5) & 255);
  endfunction

  // external memory: a narrow area answers on the upper lane only
  assign ext_din = m_wide ? {mem_byte(int'(ext_addr) & ~1), mem_byte(int'(ext_addr) | 1)}
                          : {mem_byte(int'(ext_addr)), 8'hEE};

  always @(posedge clk) begin
    m_acc <= 1'b0;
    if (!rst_n) begin
      m_st <= 0;
    end else begin
      case (m_st)
        0: if (req_valid) begin
          int n;
          longint e;
          m_acc   <= 1'b1;
          m_size  = int'(req_size);
          n = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;
          m_n     = n;
          m_base  = int'(req_addr);
          m_wide  = area_wide[req_addr[23:21]];
          m_we    = req_write;
          m_wdata = longint'(req_wdata);
          m_beat  = 0;
          m_last  = m_wide ? ((n == 4) ? 1 : 0) : n - 1;
          e = 0;
          for (int i = 0; i < n; i++) e = (e << 8) | longint'(mem_byte(m_base + i));
          m_exp_rd = e;
          m_err = (req_size == 2'd3) || (req_size != 2'd0 && req_addr[0]);
          m_st <= m_err ? 3 : 1;
        end
        1: m_st <= 2;
        2: if (m_beat == m_last) m_st <= 3;
           else begin m_beat <= m_beat + 1; m_st <= 1; end
        default: m_st <= 0;
      endcase
    end
  end

  function automatic int wbyte(input int j);
    return int'((m_wdata >> (8 * (m_n - 1 - j))) & 255);
  endfunction

  task automatic cmp(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit cyc, stb, ehi, elo;
      int eaddr, dhi, dlo;
      cyc = (m_st == 1 || m_st == 2);
      stb = (m_st == 2);
      ehi = 0; elo = 0; dhi = 0; dlo = 0;
      if (stb) begin
        if (!m_wide) begin ehi = 1; dhi = wbyte(m_beat); end
        else if (m_n == 1) begin
          ehi = !m_base[0]; elo = m_base[0];
          dhi = int'(m_wdata & 255); dlo = dhi;
        end else begin
          ehi = 1; elo = 1; dhi = wbyte(2 * m_beat); dlo = wbyte(2 * m_beat + 1);
        end
      end
      eaddr = (m_base + m_beat * (m_wide ? 2 : 1)) & 24'hFFFFFF;
      cmp(req_ready, m_st == 0, "R1 req_ready");
      cmp(ext_cyc, cyc, m_wide ? "R4 cycle count" : "R3 cycle count");
      cmp(ext_we, cyc && m_we, "R8 ext_we");
      cmp(ext_hi_en, ehi, m_wide ? "R6 upper strobe" : "R3 upper strobe");
      cmp(ext_lo_en, elo, m_wide ? "R6 lower strobe" : "R3 lower strobe");
      if (cyc && !stb) cmp({ext_hi_en, ext_lo_en}, 0, "R7 setup strobes");
      if (cyc) cmp(ext_addr, eaddr, "R5 ext_addr");
      if (stb && m_we && ehi) cmp(ext_dout[15:8], dhi, "R8 upper data");
      if (stb && m_we && elo) cmp(ext_dout[7:0], dlo, "R8 lower data");
      cmp(rsp_valid, m_st == 3, "R10 rsp_valid");
      cmp(rsp_err, (m_st == 3) && m_err, "R2 rsp_err");
      if (m_st == 3 && !m_err && !m_we) cmp(rsp_rdata, m_exp_rd, "R9 rsp_rdata");
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit we, input int sz, input int addr, input longint wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_size = 2'(sz);
    req_addr = 24'(addr); req_wdata = 32'(wd);
    do @(negedge clk); while (!m_acc);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    do begin @(negedge clk); guard++; end while ((m_st != 0) && guard < 100);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  localparam int NA = 24'h000100;  // area 0: narrow
  localparam int WA = 24'h200100;  // area 1: wide

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp(req_ready, 1, "R1 reset ready");
    cmp(ext_cyc, 0, "R1 reset cyc");
    cmp(rsp_valid, 0, "R1 reset rsp");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    scen = "narrow reads";     // R3 R5 R9
    issue(0, 0, NA + 3, 0); drain();
    issue(0, 1, NA + 6, 0); drain();
    issue(0, 2, NA + 8, 0); drain();
    scen = "narrow writes";    // R3 R8
    issue(1, 0, NA + 1, 64'h5A); drain();
    issue(1, 1, NA + 2, 64'hBEEF); drain();
    issue(1, 2, NA + 4, 64'h11223344); drain();
    scen = "wide reads";       // R4 R6 R9
    issue(0, 0, WA + 4, 0); drain();
    issue(0, 0, WA + 5, 0); drain();
    issue(0, 1, WA + 6, 0); drain();
    issue(0, 2, WA + 8, 0); drain();
    scen = "wide writes";      // R4 R6 R8
    issue(1, 0, WA + 2, 64'hC3); drain();
    issue(1, 0, WA + 3, 64'h3C); drain();
    issue(1, 1, WA + 10, 64'hA1B2); drain();
    issue(1, 2, WA + 12, 64'hCAFEF00D); drain();
    scen = "rejects";          // R2
    issue(0, 1, NA + 1, 0); drain();
    issue(1, 2, WA + 3, 64'h1); drain();
    issue(0, 3, WA, 0); drain();
    scen = "back to back";     // R1 R10 held request waits while busy
    issue(0, 2, NA + 16, 0);
    issue(0, 2, WA + 20, 0);
    issue(1, 1, 24'h600040, 64'h7788);   // area 3: wide
    drain();
    scen = "R11 config flip";  // width latched at acceptance
    issue(0, 2, NA + 32, 0);
    area_wide[0] = 1'b1;
    area_wide[1] = 1'b0;
    drain();
    issue(1, 2, WA + 40, 64'h0BADCAFE);
    area_wide[1] = 1'b1;
    drain();
    area_wide = 8'b1010_1010;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule